// File: doc/BRIEF.md
# Memory-to-I/O Output Sequencer

This block carries out the string-output operations of an 8-bit-data processor core. It moves one byte at a time from a memory location addressed by a 24-bit pointer (HL) to an I/O port, then steps the byte counter (B), the port register (C) and the pointer. Three operations are supported:

- a single transfer with an incrementing port;
- a repeated transfer with an incrementing port;
- a repeated transfer to a fixed port, where the whole BC pair forms the port address.

The core pulses `start_i` with the operation code and the current register values. The sequencer then runs a read handshake with memory and a write handshake with the I/O space for each byte. It updates the zero and sign flags after every transfer. While it runs, `busy_o` stays high. At the end it pulses `done_o`, and the core picks up the final register values from the outputs. With every start it also reports how many processor cycles the operation is rated at.

Top module: `io_out_seq`

## Requirements
- R1: Operation code 0 (single step) performs exactly one transfer. Afterwards B is one less, C one more and HL one more, all modulo their width. A starting B of 0 ends as FFh.
- R2: Operation codes 1 (repeat, incrementing port) and 2 (repeat, fixed port) keep transferring until B reaches 0. A starting B of N performs N transfers, and a starting B of 0 performs 256.
- R3: For operation codes 0, 1 and 3, each I/O write uses port address bits [7:0] equal to the current C and bits [15:8] equal to zero. C increments after each transfer and wraps from FFh to 00h.
- R4: For operation code 2, each I/O write uses port address {B, C}, where B is the value before that transfer's decrement. C is unchanged at the end.
- R5: Each transfer reads memory at the current HL. The byte returned on the read handshake is written unchanged to the port, and `io_data_o` stays stable until the write is acknowledged.
- R6: With `long_i` high, HL increments as a 24-bit value that wraps to 0. With `long_i` low, only bits [15:0] increment and wrap, and bits [23:16] are held.
- R7: After each transfer, `flag_z_o` is 1 exactly when the decremented B is zero.
- R8: After each transfer, `flag_n_o` equals bit 7 of the byte just written.
- R9: One cycle after a start, `cycles_o` holds the rated cycle count. For the single step this is 5, plus 1 with `prefix_i`. For a repeat it is 2 + 3·N, plus 1 with `prefix_i`, where N is the transfer count from R2.
- R10: `busy_o` rises on the cycle after a start and falls in the cycle after the last write acknowledge. In that same cycle `done_o` is high for exactly one cycle. A memory read request and an I/O write request are never raised together.
- R11: A start, operation code or register inputs presented while `busy_o` is high have no effect on the running operation or its results.
- R12: After reset, `busy_o`, `done_o`, both request outputs and both flags are 0.
- R13: Operation code 3 behaves exactly as the single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| op_i | input | 2 | Operation code: 0 single, 1 repeat incrementing port, 2 repeat fixed port, 3 as 0 |
| prefix_i | input | 1 | Operation carried a mode prefix byte (one extra cycle) |
| long_i | input | 1 | 24-bit pointer arithmetic |
| b_i | input | 8 | Starting byte counter |
| c_i | input | 8 | Starting port register |
| hl_i | input | 24 | Starting memory pointer |
| b_o | output | 8 | Current byte counter |
| c_o | output | 8 | Current port register |
| hl_o | output | 24 | Current memory pointer |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge; data valid |
| mem_data_i | input | 8 | Memory read data |
| io_req_o | output | 1 | I/O write request |
| io_addr_o | output | 16 | I/O port address |
| io_data_o | output | 8 | I/O write data |
| io_ack_i | input | 1 | I/O write acknowledge |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Sign flag from the transferred byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 10 | Rated cycle count of the running operation |

## Verification
The assertions assume two things about the environment. First, the memory and I/O acknowledges only matter while their own request is high. Second, `mem_data_i` is valid in the cycle its acknowledge is sampled. The bench follows both rules: it raises an acknowledge only on a falling edge where the matching request is visible, and it supplies read data from an address-derived pattern in that same cycle. Random stalls on both handshakes vary the transfer timing. Stray starts with junk register values are injected mid-run, so the bench can observe at the outputs that they were ignored.

// File: rtl/io_out_seq_pkg.sv
package io_out_seq_pkg;
  typedef enum logic [1:0] {
    OP_STEP    = 2'd0,
    OP_RPT_INC = 2'd1,
    OP_RPT_FIX = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;
endpackage

// File: rtl/io_seq_ctrl.sv
module io_seq_ctrl
  import io_out_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_ack_i,
  input  logic io_ack_i,
  input  logic final_i,
  output logic load_o,
  output logic capture_o,
  output logic step_o,
  output logic mem_req_o,
  output logic io_req_o,
  output logic busy_o,
  output logic done_o
);
  st_e st_q, st_d;
  logic done_q;

  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign capture_o = (st_q == ST_READ) && mem_ack_i;
  assign step_o    = (st_q == ST_WRITE) && io_ack_i;
  assign mem_req_o = (st_q == ST_READ);
  assign io_req_o  = (st_q == ST_WRITE);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_READ;
      ST_READ:  if (mem_ack_i) st_d = ST_WRITE;
      ST_WRITE: if (io_ack_i) st_d = final_i ? ST_IDLE : ST_READ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= step_o && final_i;
    end
  end
endmodule

// File: rtl/io_seq_regs.sv
module io_seq_regs
  import io_out_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic              step_i,
  input  logic [1:0]        op_i,
  input  logic              long_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output op_e               op_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] c_o,
  output logic [ADDR_W-1:0] hl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              z_o,
  output logic              n_o,
  output logic              final_o
);
  localparam int SHORT_W = 2 * DATA_W;

  op_e               op_q;
  logic              long_q;
  logic [DATA_W-1:0] b_q, c_q, data_q;
  logic [ADDR_W-1:0] hl_q, hl_nxt;
  logic [DATA_W-1:0] b_nxt;
  logic              z_q, n_q;

  assign b_nxt = b_q - DATA_W'(1);

  // pointer wrap: full width in long mode, low half only otherwise
  generate
    if (ADDR_W > SHORT_W) begin : g_split
      assign hl_nxt = long_q ? hl_q + ADDR_W'(1)
                             : {hl_q[ADDR_W-1:SHORT_W], hl_q[SHORT_W-1:0] + SHORT_W'(1)};
    end else begin : g_flat
      logic unused_long;
      assign unused_long = long_q;
      assign hl_nxt = hl_q + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_STEP;
      long_q <= 1'b0;
      b_q    <= '0;
      c_q    <= '0;
      hl_q   <= '0;
      data_q <= '0;
      z_q    <= 1'b0;
      n_q    <= 1'b0;
    end else if (load_i) begin
      op_q   <= (op_i == OP_RSVD) ? OP_STEP : op_e'(op_i);
      long_q <= long_i;
      b_q    <= b_i;
      c_q    <= c_i;
      hl_q   <= hl_i;
    end else if (capture_i) begin
      data_q <= mem_data_i;
    end else if (step_i) begin
      b_q  <= b_nxt;
      hl_q <= hl_nxt;
      if (op_q != OP_RPT_FIX) c_q <= c_q + DATA_W'(1);
      z_q  <= (b_nxt == '0);
      n_q  <= data_q[DATA_W-1];
    end
  end

  assign op_o    = op_q;
  assign b_o     = b_q;
  assign c_o     = c_q;
  assign hl_o    = hl_q;
  assign data_o  = data_q;
  assign z_o     = z_q;
  assign n_o     = n_q;
  assign final_o = (op_q == OP_STEP) || (b_q == DATA_W'(1));
endmodule

// File: rtl/io_addr_gen.sv
module io_addr_gen
  import io_out_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IO_W  = 2 * DATA_W
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [IO_W-1:0]   addr_o
);
  assign addr_o = (op_i == OP_RPT_FIX) ? {b_i, c_i} : {{DATA_W{1'b0}}, c_i};
endmodule

// File: rtl/io_cycle_calc.sv
module io_cycle_calc
  import io_out_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CYC_W = DATA_W + 2
) (
  input  logic [1:0]        op_i,
  input  logic              prefix_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [CYC_W-1:0]  cycles_o
);
  logic [CYC_W-1:0] n_xfer;
  logic             rpt;

  assign rpt    = (op_i == OP_RPT_INC) || (op_i == OP_RPT_FIX);
  assign n_xfer = (b_i == '0) ? CYC_W'(1 << DATA_W) : CYC_W'(b_i);

  always_comb begin
    if (rpt) cycles_o = CYC_W'(2) + CYC_W'(prefix_i) + CYC_W'(3) * n_xfer;
    else     cycles_o = CYC_W'(5) + CYC_W'(prefix_i);
  end
endmodule

// File: rtl/io_out_seq.sv
module io_out_seq
  import io_out_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 24,
  localparam int IO_W   = 2 * DATA_W,
  localparam int CYC_W  = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              prefix_i,
  input  logic              long_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [ADDR_W-1:0] hl_i,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] c_o,
  output logic [ADDR_W-1:0] hl_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              io_req_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic [DATA_W-1:0] io_data_o,
  input  logic              io_ack_i,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CYC_W-1:0]  cycles_o
);
  logic             load, capture, step, fin;
  op_e              op_q;
  logic [CYC_W-1:0] cyc_calc, cyc_q;

  io_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_ack_i (mem_ack_i),
    .io_ack_i  (io_ack_i),
    .final_i   (fin),
    .load_o    (load),
    .capture_o (capture),
    .step_o    (step),
    .mem_req_o (mem_req_o),
    .io_req_o  (io_req_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  io_seq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .capture_i  (capture),
    .step_i     (step),
    .op_i       (op_i),
    .long_i     (long_i),
    .b_i        (b_i),
    .c_i        (c_i),
    .hl_i       (hl_i),
    .mem_data_i (mem_data_i),
    .op_o       (op_q),
    .b_o        (b_o),
    .c_o        (c_o),
    .hl_o       (hl_o),
    .data_o     (io_data_o),
    .z_o        (flag_z_o),
    .n_o        (flag_n_o),
    .final_o    (fin)
  );

  io_addr_gen #(.DATA_W(DATA_W)) u_addr (
    .op_i   (op_q),
    .b_i    (b_o),
    .c_i    (c_o),
    .addr_o (io_addr_o)
  );

  io_cycle_calc #(.DATA_W(DATA_W)) u_cyc (
    .op_i     (op_i),
    .prefix_i (prefix_i),
    .b_i      (b_i),
    .cycles_o (cyc_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cyc_q <= '0;
    else if (load) cyc_q <= cyc_calc;
  end

  assign cycles_o   = cyc_q;
  assign mem_addr_o = hl_o;
endmodule

// File: rtl/io_out_seq_chk.sv
module io_out_seq_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24,
  localparam int IO_W  = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_q,
  input logic [DATA_W-1:0] b_o,
  input logic [DATA_W-1:0] c_o,
  input logic [ADDR_W-1:0] hl_o,
  input logic              mem_req_o,
  input logic              io_req_o,
  input logic              io_ack_i,
  input logic [IO_W-1:0]   io_addr_o,
  input logic [DATA_W-1:0] io_data_o,
  input logic              flag_z_o,
  input logic              flag_n_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int SHORT_W = 2 * DATA_W;

  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && io_req_o));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(io_req_o && io_ack_i)) |=> busy_o);

  p_b_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && io_ack_i) |=> (b_o == $past(b_o) - DATA_W'(1)));

  p_hl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && io_ack_i) |=> (hl_o[SHORT_W-1:0] == $past(hl_o[SHORT_W-1:0]) + SHORT_W'(1)));

  p_inc_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && op_q != 2'd2) |-> (io_addr_o == {{DATA_W{1'b0}}, c_o}));

  p_fix_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && op_q == 2'd2) |-> (io_addr_o == {b_o, c_o}));

  p_fix_c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && io_ack_i && op_q == 2'd2) |=> $stable(c_o));

  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && !io_ack_i) |=> ($stable(io_data_o) && io_req_o));

  p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && io_ack_i) |=> (flag_z_o == (b_o == '0)));

  p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && io_ack_i) |=> (flag_n_o == $past(io_data_o[DATA_W-1])));
endmodule

bind io_out_seq io_out_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_q      (op_q),
  .b_o       (b_o),
  .c_o       (c_o),
  .hl_o      (hl_o),
  .mem_req_o (mem_req_o),
  .io_req_o  (io_req_o),
  .io_ack_i  (io_ack_i),
  .io_addr_o (io_addr_o),
  .io_data_o (io_data_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/io_out_seq_tb_top.sv
module io_out_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, prefix_i, long_i, mem_ack_i, io_ack_i;
  logic [1:0]  op_i;
  logic [7:0]  b_i, c_i, mem_data_i;
  logic [23:0] hl_i;
  logic [7:0]  b_o, c_o, io_data_o;
  logic [23:0] hl_o, mem_addr_o;
  logic        mem_req_o, io_req_o, flag_z_o, flag_n_o, busy_o, done_o;
  logic [15:0] io_addr_o;
  logic [9:0]  cycles_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  io_out_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i),
    .prefix_i(prefix_i), .long_i(long_i), .b_i(b_i), .c_i(c_i), .hl_i(hl_i),
    .b_o(b_o), .c_o(c_o), .hl_o(hl_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i),
    .io_req_o(io_req_o), .io_addr_o(io_addr_o), .io_data_o(io_data_o),
    .io_ack_i(io_ack_i), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
    .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] t;
    t = a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16];
    return t * 8'd151 + 8'd7;
  endfunction

  function automatic logic [23:0] hl_step(input logic [23:0] h, input bit lng);
    return lng ? h + 24'd1 : {h[23:16], h[15:0] + 16'd1};
  endfunction

  function automatic int n_xfers(input logic [1:0] op, input logic [7:0] b);
    if (op == 2'd1 || op == 2'd2) return (b == 8'd0) ? 256 : int'(b);
    return 1;
  endfunction

  function automatic int rated(input logic [1:0] op, input logic [7:0] b, input bit pre);
    if (op == 2'd1 || op == 2'd2) return 2 + int'(pre) + 3 * n_xfers(op, b);
    return 5 + int'(pre);
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [7:0] b, input logic [7:0] c,
                        input logic [23:0] hl, input bit pre, input bit lng, input bit stray);
    logic [7:0]  eb = b;
    logic [7:0]  ec = c;
    logic [23:0] ehl = hl;
    logic [15:0] eaddr;
    bit pend = 0, seen_mem = 0, seen_io = 0, lastn = 0, got_done = 0;
    int nx = 0;
    string rq;
    rq = (op == 2'd2) ? "R4" : "R3";
    @(negedge clk);
    start_i = 1'b1; op_i = op; b_i = b; c_i = c; hl_i = hl; prefix_i = pre; long_i = lng;
    @(negedge clk);
    start_i = 1'b0;
    b_i = 8'($urandom); c_i = 8'($urandom); hl_i = 24'($urandom); long_i = ~lng;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    chk(int'(cycles_o) == rated(op, b, pre), "R9 cycles", cycles_o, rated(op, b, pre));
    for (int t = 0; t < 6000; t++) begin
      if (pend) begin
        chk(b_o == eb, (op == 2'd0 || op == 2'd3) ? "R1 b" : "R2 b", b_o, eb);
        chk(c_o == ec, {rq, " c"}, c_o, ec);
        chk(hl_o == ehl, "R6 hl", hl_o, ehl);
        chk(flag_z_o == (eb == 8'd0), "R7 z", flag_z_o, (eb == 8'd0));
        chk(flag_n_o == lastn, "R8 n", flag_n_o, lastn);
        pend = 0;
      end
      if (done_o) begin got_done = 1; break; end
      mem_ack_i = 1'b0; io_ack_i = 1'b0; start_i = 1'b0;
      if (mem_req_o) begin
        if (!seen_mem) begin
          chk(mem_addr_o == ehl, "R5 mem addr", mem_addr_o, ehl);
          seen_mem = 1;
        end
        if ($urandom % 3 != 0) begin
          mem_ack_i = 1'b1; mem_data_i = mem_byte(ehl); seen_mem = 0;
        end else mem_data_i = 8'($urandom);
      end
      if (io_req_o) begin
        eaddr = (op == 2'd2) ? {eb, ec} : {8'h00, ec};
        if (!seen_io) begin
          chk(io_addr_o == eaddr, {rq, " io addr"}, io_addr_o, eaddr);
          chk(io_data_o == mem_byte(ehl), "R5 io data", io_data_o, mem_byte(ehl));
          seen_io = 1;
        end
        if ($urandom % 3 != 0) begin
          io_ack_i = 1'b1; seen_io = 0;
          lastn = mem_byte(ehl) >> 7;
          eb = eb - 8'd1;
          if (op != 2'd2) ec = ec + 8'd1;
          ehl = hl_step(ehl, lng);
          nx++; pend = 1;
        end
      end
      if (stray && busy_o && ($urandom % 4 == 0)) begin
        start_i = 1'b1; op_i = 2'($urandom); b_i = 8'($urandom); prefix_i = ~pre;
      end
      @(negedge clk);
    end
    mem_ack_i = 1'b0; io_ack_i = 1'b0; start_i = 1'b0;
    chk(got_done, "R10 done seen", got_done, 1);
    chk(busy_o == 1'b0, "R10 busy low at done", busy_o, 0);
    chk(nx == n_xfers(op, b), (op == 2'd3) ? "R13 count" : ((op == 2'd0) ? "R1 count" : "R2 count"),
        nx, n_xfers(op, b));
    chk(int'(cycles_o) == rated(op, b, pre), "R11 cycles unchanged", cycles_o, rated(op, b, pre));
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; prefix_i = 1'b0; long_i = 1'b0;
    b_i = '0; c_i = '0; hl_i = '0; mem_ack_i = 1'b0; io_ack_i = 1'b0; mem_data_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R12 busy/done", {busy_o, done_o}, 0);
    chk(mem_req_o == 0 && io_req_o == 0, "R12 req", {mem_req_o, io_req_o}, 0);
    chk(flag_z_o == 0 && flag_n_o == 0, "R12 flags", {flag_z_o, flag_n_o}, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(2'd0, 8'd5,  8'h10, 24'h001234, 0, 0, 0); // R1
    run_op(2'd0, 8'd0,  8'hFF, 24'h12FFFF, 1, 0, 0); // R1 B wrap, C wrap, R6 short
    run_op(2'd0, 8'd1,  8'h20, 24'hFFFFFF, 0, 1, 0); // R7 Z set, R6 long wrap
    run_op(2'd1, 8'd3,  8'hFE, 24'h00FFFE, 1, 0, 0); // R2 R3
    run_op(2'd2, 8'd4,  8'hFE, 24'h3400F0, 0, 1, 1); // R4 R11
    run_op(2'd2, 8'd0,  8'h55, 24'h000100, 1, 0, 0); // R2 256 transfers
    run_op(2'd3, 8'd2,  8'h33, 24'h0A0B0C, 0, 0, 1); // R13
    run_op(2'd1, 8'd6,  8'hFC, 24'hFFFFFC, 0, 1, 1); // R6 long wrap mid-run
    for (int i = 0; i < 40; i++) begin
      logic [7:0] rb;
      rb = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom % 24);
      run_op(2'($urandom), rb, 8'($urandom), 24'($urandom), bit'($urandom), bit'($urandom),
             bit'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule